// File: doc/BRIEF.md
# Converter Soft-Start and Fault Sequencer

This block sequences the digital reference of a multiphase buck regulator. Once the converter is enabled and its supplies are reported healthy, it holds the reference at zero for a fixed number of switching cycles. It then ramps the reference linearly up to one of four set-points and raises power-good when the set-point is reached. Every timing step is counted on a one-cycle switching tick. The core clock can therefore run much faster than the power stage.

The block gates the drivers around the soft-start. If the output is already charged, the drivers stay off until the ramp overtakes the digitized feedback voltage. On an overcurrent flag during the ramp or in regulation, the drivers are cut in the same cycle. A fixed hiccup pause follows, and then a complete new start. An overvoltage flag forces the low-side switches on whatever the sequence is doing. The sequence itself keeps running underneath.

Top module: `softstart_seq`

## Requirements
- R1: While `enable` or `por_good` is low, `drive_en` and `power_good` are low in that same cycle, and `vref_mv` is 0 from the next clock edge on. Reasserting both inputs restarts the whole sequence with a full delay.
- R2: After both `enable` and `por_good` are high, one clock edge leaves idle. `vref_mv` then stays at 0 for the next 240 tick edges (edges with `sw_tick` high).
- R3: `vref_sel` selects the set-point in millivolts: 0 gives 600, 1 gives 900, 2 gives 1200 and 3 gives 1500. `vref_mv` and `vfb_mv` are in units of 1 mV.
- R4: After k ramp ticks with k < 1690, `vref_mv` equals floor(k·s/4096), where s = floor(T·4096/1690) and T is the set-point. At the 1690th ramp tick it becomes exactly T. The set-point is captured when the ramp starts, so later changes of `vref_sel` have no effect until the next start.
- R5: The delay, ramp and hiccup counters advance only on clock edges where `sw_tick` is high. Between ticks `vref_mv` holds.
- R6: `power_good` is high only in regulation. It rises at the same edge at which `vref_mv` reaches the set-point.
- R7: During the ramp, `drive_en` stays low until the first edge at which the `vref_mv` shown in the previous cycle was above `vfb_mv`, and then stays high. If `vfb_mv` is above the set-point, `drive_en` stays low for the whole ramp and rises when regulation begins.
- R8: When `oc_det` is high during the ramp or in regulation, `drive_en` and `power_good` drop in that same cycle. At the next edge the block enters hiccup with `vref_mv` at 0. After 4096 ticks it starts the 240-tick delay again.
- R9: `oc_det` has no effect during the start delay or the hiccup pause. A persisting overcurrent repeats the hiccup-and-restart loop without limit.
- R10: With `por_good` high, `ov_det` drives `low_side_on` high and forces `drive_en` and `power_good` low in the same cycle, in any state and regardless of `enable`. The sequence timing continues meanwhile, and the outputs resume once the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable |
| por_good | input | 1 | Supplies above their power-on-reset levels |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| vref_sel | input | 2 | Set-point code |
| vfb_mv | input | 12 | Digitized output feedback, mV |
| oc_det | input | 1 | Overcurrent flag |
| ov_det | input | 1 | Overvoltage flag |
| vref_mv | output | 12 | Ramping reference, mV |
| drive_en | output | 1 | Enable for both switch sets |
| low_side_on | output | 1 | Forces the low-side switches on |
| power_good | output | 1 | Output in regulation |

## Verification
Corrupting the sequencer state shows up at the ports at the next tick edge. A miscounted delay, ramp or hiccup window shifts the edge at which `power_good` rises. The bench therefore samples `power_good` in the cycles on both sides of the expected edge. A wrong accumulator step shows up as a `vref_mv` value that no longer matches the floor formula at mid-ramp. A stale crossing flag makes `drive_en` lead or lag the first cycle in which the reference exceeds the feedback. Fault masking is combinational, so a missing term in it is visible in the very cycle the flag is raised.

// File: rtl/ssq_pkg.sv
`timescale 1ns/1ps
package ssq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RAMP,
    ST_RUN,
    ST_HICCUP
  } ssq_state_t;

  // Set-point in mV for a 2-bit selection code
  function automatic int unsigned level_for_code(input logic [1:0] code,
                                                 input int unsigned base_mv,
                                                 input int unsigned inc_mv);
    int unsigned c;
    c = {30'd0, code};
    return base_mv + inc_mv * c;
  endfunction

  // Fixed-point per-tick increment that covers level in the given tick count
  function automatic int unsigned ramp_increment(input int unsigned level,
                                                 input int unsigned frac_w,
                                                 input int unsigned ticks);
    return (level << frac_w) / ticks;
  endfunction

endpackage

// File: rtl/ssq_ctrl.sv
`timescale 1ns/1ps
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int unsigned DELAY_TICKS  = 240,
  parameter int unsigned RAMP_TICKS   = 1690,
  parameter int unsigned HICCUP_TICKS = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       tick,
  input  logic       oc_flag,
  output ssq_state_t st,
  output logic       ramp_load,
  output logic       ramp_adv,
  output logic       ramp_end,
  output logic       oc_trip
);

  localparam int unsigned LONG_DR = (DELAY_TICKS > RAMP_TICKS) ? DELAY_TICKS : RAMP_TICKS;
  localparam int unsigned LONGEST = (HICCUP_TICKS > LONG_DR) ? HICCUP_TICKS : LONG_DR;
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] RMP_LAST = CNT_W'(RAMP_TICKS - 1);
  localparam logic [CNT_W-1:0] HIC_LAST = CNT_W'(HICCUP_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             powered_st;

  assign powered_st = (st == ST_RAMP) || (st == ST_RUN);
  assign oc_trip    = active && powered_st && oc_flag;
  assign ramp_load  = active && (st == ST_DELAY) && tick && (cnt == DLY_LAST);
  assign ramp_adv   = active && (st == ST_RAMP) && !oc_flag && tick && (cnt != RMP_LAST);
  assign ramp_end   = active && (st == ST_RAMP) && !oc_flag && tick && (cnt == RMP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!active) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (oc_trip) begin
      st  <= ST_HICCUP;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          st  <= ST_DELAY;
          cnt <= '0;
        end
        ST_DELAY: if (tick) begin
          if (cnt == DLY_LAST) begin
            st  <= ST_RAMP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_RAMP: if (tick) begin
          if (cnt == RMP_LAST) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_RUN: cnt <= '0;
        ST_HICCUP: if (tick) begin
          if (cnt == HIC_LAST) begin
            st  <= ST_DELAY;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  // R1: losing enable or POR always lands in idle
  a_r1_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> st == ST_IDLE);

  // R9: overcurrent cannot leave the delay for hiccup
  a_r9_delay_ignores_oc: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == ST_DELAY) |=> (st == ST_DELAY || st == ST_RAMP));

  // R8: a trip while powered lands in hiccup
  a_r8_trip_to_hiccup: assert property (@(posedge clk) disable iff (!rst_n)
    (active && oc_flag && (st == ST_RAMP || st == ST_RUN)) |=> st == ST_HICCUP);

  // R8: hiccup only ends into a fresh delay
  a_r8_hiccup_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == ST_HICCUP) |=> (st == ST_HICCUP || st == ST_DELAY));

  // R5: without a tick the timed states hold
  a_r5_timed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && (st == ST_DELAY || st == ST_HICCUP || (st == ST_RAMP && !oc_flag)))
    |=> $stable(st));

endmodule

// File: rtl/ssq_ramp.sv
`timescale 1ns/1ps
module ssq_ramp
  import ssq_pkg::*;
#(
  parameter int unsigned REF_W      = 12,
  parameter int unsigned FRAC_W     = 12,
  parameter int unsigned RAMP_TICKS = 1690,
  parameter int unsigned BASE_MV    = 600,
  parameter int unsigned INC_MV     = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             fin,
  input  logic [1:0]       code,
  input  logic [REF_W-1:0] fb_mv,
  output logic [REF_W-1:0] ramp_mv,
  output logic [REF_W-1:0] goal_mv,
  output logic             crossed
);

  localparam int ACC_W = REF_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] acc_sum;
  logic [REF_W-1:0] goal_now;
  logic [ACC_W-1:0] step_now;

  assign goal_now = REF_W'(level_for_code(code, BASE_MV, INC_MV));
  assign step_now = ACC_W'(ramp_increment(level_for_code(code, BASE_MV, INC_MV),
                                          FRAC_W, RAMP_TICKS));
  assign acc_sum  = acc_q + step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      step_q  <= '0;
      goal_mv <= '0;
      ramp_mv <= '0;
    end else if (load) begin
      acc_q   <= '0;
      step_q  <= step_now;
      goal_mv <= goal_now;
      ramp_mv <= '0;
    end else if (fin) begin
      acc_q   <= {goal_mv, {FRAC_W{1'b0}}};
      ramp_mv <= goal_mv;
    end else if (adv) begin
      acc_q   <= acc_sum;
      ramp_mv <= acc_sum[ACC_W-1 -: REF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crossed <= 1'b0;
    else if (load)             crossed <= 1'b0;
    else if (ramp_mv > fb_mv)  crossed <= 1'b1;
  end

  // R4: the ramp never overshoots the captured set-point
  a_r4_within_goal: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_mv <= goal_mv);

  // R4: each advance never lowers the reference
  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ramp_mv >= $past(ramp_mv));

  // R7: once crossed, the flag holds until the next ramp start
  a_r7_crossed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (crossed && !load) |=> crossed);

endmodule

// File: rtl/softstart_seq.sv
`timescale 1ns/1ps
module softstart_seq
  import ssq_pkg::*;
#(
  parameter int unsigned REF_W        = 12,
  parameter int unsigned FRAC_W       = 12,
  parameter int unsigned DELAY_TICKS  = 240,
  parameter int unsigned RAMP_TICKS   = 1690,
  parameter int unsigned HICCUP_TICKS = 4096,
  parameter int unsigned BASE_MV      = 600,
  parameter int unsigned INC_MV       = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             por_good,
  input  logic             sw_tick,
  input  logic [1:0]       vref_sel,
  input  logic [REF_W-1:0] vfb_mv,
  input  logic             oc_det,
  input  logic             ov_det,
  output logic [REF_W-1:0] vref_mv,
  output logic             drive_en,
  output logic             low_side_on,
  output logic             power_good
);

  ssq_state_t       st;
  logic             active;
  logic             ramp_load;
  logic             ramp_adv;
  logic             ramp_end;
  logic             oc_trip;
  logic [REF_W-1:0] ramp_mv;
  logic [REF_W-1:0] goal_mv;
  logic             crossed;
  logic             in_ramp;
  logic             in_run;

  assign active  = enable && por_good;
  assign in_ramp = (st == ST_RAMP);
  assign in_run  = (st == ST_RUN);

  ssq_ctrl #(
    .DELAY_TICKS (DELAY_TICKS),
    .RAMP_TICKS  (RAMP_TICKS),
    .HICCUP_TICKS(HICCUP_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .tick     (sw_tick),
    .oc_flag  (oc_det),
    .st       (st),
    .ramp_load(ramp_load),
    .ramp_adv (ramp_adv),
    .ramp_end (ramp_end),
    .oc_trip  (oc_trip)
  );

  ssq_ramp #(
    .REF_W     (REF_W),
    .FRAC_W    (FRAC_W),
    .RAMP_TICKS(RAMP_TICKS),
    .BASE_MV   (BASE_MV),
    .INC_MV    (INC_MV)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ramp_load),
    .adv    (ramp_adv),
    .fin    (ramp_end),
    .code   (vref_sel),
    .fb_mv  (vfb_mv),
    .ramp_mv(ramp_mv),
    .goal_mv(goal_mv),
    .crossed(crossed)
  );

  assign vref_mv     = (in_ramp || in_run) ? ramp_mv : '0;
  assign drive_en    = active && !ov_det && !oc_det && (in_run || (in_ramp && crossed));
  assign low_side_on = por_good && ov_det;
  assign power_good  = active && in_run && !ov_det && !oc_det;

  // R1: an inactive converter never drives and never reports good
  a_r1_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!drive_en && !power_good));

  // R1: the reference is zero one edge after losing enable or POR
  a_r1_ref_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> vref_mv == '0);

  // R6: power-good implies the reference sits on the set-point with drivers on
  a_r6_good_at_goal: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> (vref_mv == goal_mv && drive_en));

  // R8: a trip zeroes the reference at the next edge
  a_r8_trip_zeroes_ref: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |=> (vref_mv == '0 && !power_good));

  // R10: overvoltage clamps the low side and blocks everything else
  a_r10_ov_override: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_det && por_good) |-> (low_side_on && !drive_en && !power_good));

endmodule

// File: tb/test_softstart_seq.sv
`timescale 1ns/1ps
module test_softstart_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        por_good = 1'b0;
  logic        sw_tick = 1'b0;
  logic [1:0]  vref_sel = 2'd0;
  logic [11:0] vfb_mv = '0;
  logic        oc_det = 1'b0;
  logic        ov_det = 1'b0;
  logic [11:0] vref_mv;
  logic        drive_en;
  logic        low_side_on;
  logic        power_good;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  softstart_seq i_softstart_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .por_good(por_good),
    .sw_tick(sw_tick), .vref_sel(vref_sel), .vfb_mv(vfb_mv),
    .oc_det(oc_det), .ov_det(ov_det), .vref_mv(vref_mv),
    .drive_en(drive_en), .low_side_on(low_side_on), .power_good(power_good)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int goal_of(input int code);
    return 600 + code * 300;
  endfunction

  function automatic int model_ref(input int code, input int k);
    int inc;
    if (k >= 1690) return goal_of(code);
    inc = (goal_of(code) * 4096) / 1690;
    return (k * inc) / 4096;
  endfunction

  // Advance n ticks; each tick is one edge with sw_tick high plus gap-1 quiet edges
  task automatic adv(input int n, input int gap = 1);
    for (int i = 0; i < n; i++) begin
      sw_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      sw_tick = 1'b0;
      for (int j = 1; j < gap; j++) begin
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  task automatic start(input int code, input int fb);
    enable = 1'b0; por_good = 1'b1; oc_det = 1'b0; ov_det = 1'b0;
    @(posedge clk); @(negedge clk);
    vref_sel = 2'(code); vfb_mv = 12'(fb); enable = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    check(vref_mv == 0, "R1 reset ref", int'(vref_mv), 0);
    check(!drive_en && !power_good && !low_side_on, "R1 reset flags",
          int'({drive_en, power_good, low_side_on}), 0);
  endtask

  task automatic t_delay_ramp;
    start(0, 0);
    adv(239);
    check(vref_mv == 0, "R2 delay hold", int'(vref_mv), 0);
    adv(1);
    check(vref_mv == 0, "R2 ramp entry", int'(vref_mv), 0);
    adv(845);
    check(vref_mv == model_ref(0, 845), "R4 mid ramp", int'(vref_mv), model_ref(0, 845));
    check(!power_good, "R6 low in ramp", int'(power_good), 0);
    check(drive_en, "R7 driving after crossing", int'(drive_en), 1);
    adv(844);
    check(vref_mv == model_ref(0, 1689), "R4 last ramp step", int'(vref_mv), model_ref(0, 1689));
    check(!power_good, "R6 low before goal", int'(power_good), 0);
    adv(1);
    check(vref_mv == 600, "R3 code 0", int'(vref_mv), 600);
    check(power_good, "R6 good at goal", int'(power_good), 1);
  endtask

  task automatic t_codes;
    for (int c = 1; c < 4; c++) begin
      start(c, 0);
      adv(340);
      vref_sel = 2'(c ^ 3);
      adv(1590);
      check(vref_mv == 12'(goal_of(c)), "R3 R4 code map with late change",
            int'(vref_mv), goal_of(c));
    end
  endtask

  task automatic t_precharge;
    bit seen = 1'b0;
    int bad = 0;
    start(3, 700);
    adv(240);
    for (int k = 0; k < 1690; k++) begin
      if (drive_en != seen) bad++;
      if (vref_mv > 700) seen = 1'b1;
      adv(1);
    end
    check(bad == 0, "R7 precharged drive follows crossing", bad, 0);
    check(seen, "R7 ramp crossed feedback", int'(seen), 1);
    check(drive_en && vref_mv == 1500, "R7 run after precharge", int'(vref_mv), 1500);
  endtask

  task automatic t_overcharged;
    int on = 0;
    start(2, 1600);
    adv(240);
    for (int k = 0; k < 1690; k++) begin
      if (drive_en) on++;
      adv(1);
    end
    check(on == 0, "R7 off across ramp when above goal", on, 0);
    check(drive_en && power_good, "R7 drivers on at run", int'({drive_en, power_good}), 3);
    check(vref_mv == 1200, "R3 code 2", int'(vref_mv), 1200);
  endtask

  task automatic t_oc_hiccup;
    start(1, 0);
    adv(1930);
    oc_det = 1'b1; #1;
    check(!drive_en && !power_good, "R8 same-cycle cut", int'({drive_en, power_good}), 0);
    adv(1);
    oc_det = 1'b0; #1;
    check(vref_mv == 0, "R8 hiccup ref zero", int'(vref_mv), 0);
    oc_det = 1'b1; adv(10); oc_det = 1'b0;
    adv(4085);
    check(vref_mv == 0 && !drive_en, "R8 still in hiccup", int'(vref_mv), 0);
    adv(1);
    oc_det = 1'b1; adv(5); oc_det = 1'b0;
    adv(235);
    adv(1689);
    check(!power_good, "R9 oc in delay ignored, before goal", int'(power_good), 0);
    adv(1);
    check(power_good && vref_mv == 900, "R9 oc in delay ignored, goal", int'(vref_mv), 900);
  endtask

  task automatic t_oc_retry;
    int drv = 0;
    start(0, 0);
    adv(1930);
    oc_det = 1'b1;
    adv(1);
    for (int k = 0; k < 4096 + 240 + 1 + 3; k++) begin
      if (drive_en) drv++;
      adv(1);
    end
    oc_det = 1'b0;
    check(drv == 0, "R9 drivers off while retrying", drv, 0);
    adv(4093 + 240 + 1689);
    check(!power_good, "R9 second retry timing before", int'(power_good), 0);
    adv(1);
    check(power_good, "R9 second retry timing goal", int'(power_good), 1);
  endtask

  task automatic t_ov;
    start(2, 0);
    adv(1930);
    ov_det = 1'b1; #1;
    check(low_side_on && !drive_en && !power_good, "R10 clamp in run",
          int'({low_side_on, drive_en, power_good}), 4);
    adv(5);
    check(vref_mv == 1200, "R10 reference kept", int'(vref_mv), 1200);
    ov_det = 1'b0; #1;
    check(power_good && drive_en && !low_side_on, "R10 resume",
          int'({low_side_on, drive_en, power_good}), 3);
    start(0, 0);
    ov_det = 1'b1; adv(100);
    check(low_side_on, "R10 clamp in delay", int'(low_side_on), 1);
    ov_det = 1'b0;
    adv(140 + 1690);
    check(power_good, "R10 sequence kept running", int'(power_good), 1);
    enable = 1'b0; adv(1);
    ov_det = 1'b1; #1;
    check(low_side_on, "R10 clamp while disabled", int'(low_side_on), 1);
    ov_det = 1'b0;
  endtask

  task automatic t_enable_drop;
    start(3, 0);
    adv(740);
    check(vref_mv == model_ref(3, 500), "R4 code 3 ramp", int'(vref_mv), model_ref(3, 500));
    enable = 1'b0; #1;
    check(!drive_en, "R1 drive drop same cycle", int'(drive_en), 0);
    adv(1);
    check(vref_mv == 0, "R1 ref cleared", int'(vref_mv), 0);
    enable = 1'b1; adv(1);
    adv(240 + 1689);
    check(!power_good, "R1 restart uses full delay", int'(power_good), 0);
    adv(1);
    check(power_good, "R1 restart reaches goal", int'(power_good), 1);
    por_good = 1'b0; #1;
    check(!power_good, "R1 POR loss drops good", int'(power_good), 0);
    adv(1);
    check(vref_mv == 0, "R1 POR loss clears ref", int'(vref_mv), 0);
    por_good = 1'b1;
  endtask

  task automatic t_sparse;
    start(1, 0);
    adv(240, 3);
    adv(1000, 3);
    sw_tick = 1'b0;
    @(posedge clk); @(negedge clk);
    check(vref_mv == model_ref(1, 1000), "R5 hold between ticks", int'(vref_mv), model_ref(1, 1000));
    adv(689, 3);
    check(!power_good && vref_mv == model_ref(1, 1689), "R5 sparse ticks before goal",
          int'(vref_mv), model_ref(1, 1689));
    adv(1, 3);
    check(power_good && vref_mv == 900, "R5 sparse ticks goal", int'(vref_mv), 900);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_delay_ramp();
    t_codes();
    t_precharge();
    t_overcharged();
    t_oc_hiccup();
    t_oc_retry();
    t_ov();
    t_enable_drop();
    t_sparse();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule